// File: doc/BRIEF.md
# Auto-Incrementing Control Register Bank

This block is the byte-wide register store behind a peripheral's control port. A host-side framer, which handles the serial bit shifting, hands it whole bytes and four strobes: transaction start, byte valid (with the byte), read request and transaction end. The first byte after a start is not stored anywhere. Its bit 7 turns address auto-increment on or off, and bits 6:0 load a 7-bit register pointer. Each later byte is written to the register under the pointer. Each read strobe returns the byte at the pointer.

The map holds a fixed identification byte at 01h. It continues with a run of read/write configuration bytes (NUM_RW of them, starting at 02h) and then two read-only bytes fed from the surrounding logic: a status byte and a data-output byte. With the default NUM_RW = 6, the status byte is at 08h and the data-output byte at 09h. The configuration bytes drive the `cfg_out` bus. A read that arrives with no pointer byte in front of it uses whatever pointer the previous transaction left behind.

Top module: `ctrl_regbank`

## Requirements
- R1: Reset sets the pointer to 01h with auto-increment on and `rd_data` to 00h. Each read/write byte at address A resets to 80h OR A, so the defaults are 82h through 87h.
- R2: The first byte-valid after a start loads the pointer from bits 6:0 and the increment flag from bit 7. That byte writes no register.
- R3: With the increment flag at 1, the pointer advances by one after each register write or read. With the flag at 0 it stays put, so repeated accesses hit the same address.
- R4: Address 01h is read-only and always returns D1h.
- R5: Addresses 02h to NUM_RW+1 are read/write. Address 02h+i appears on `cfg_out[8*i+7:8*i]`.
- R6: A write to a read-only or unimplemented address changes no register, and the pointer still advances when the increment flag is 1.
- R7: Address NUM_RW+2 returns `stat_in` and address NUM_RW+3 returns `dout_in`. Both are read-only.
- R8: An advance from address NUM_RW+3 or any higher address gives 00h. Reads of 00h or of addresses above NUM_RW+3 return 00h.
- R9: A read with no pointer byte before it in the transaction uses the pointer left by the previous transaction.
- R10: `rd_data` takes the addressed byte at the clock edge that samples the read strobe, and holds its value in every cycle without an accepted read.
- R11: Byte-valid and read strobes between an end and the next start are ignored. Within a cycle the strobes rank as start, then end, then byte-valid, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Transaction start strobe |
| txn_end | input | 1 | Transaction end strobe |
| byte_valid | input | 1 | Byte-valid strobe for `byte_in` |
| byte_in | input | 8 | Pointer byte or write data |
| rd_strobe | input | 1 | Read request for the byte at the pointer |
| stat_in | input | 8 | Status value, read-only |
| dout_in | input | 8 | Data-output value, read-only |
| rd_data | output | 8 | Registered read result |
| cfg_out | output | 8*NUM_RW | Configuration register contents |

## Verification
The hardest case to reach from the ports is the pointer wrapping from the top of the map back to 00h. Close behind it are writes that must be dropped while the pointer still moves, because a dropped write leaves nothing visible at the port where it happened. The stimulus parks the pointer on the last read-only byte and then keeps reading or writing across the wrap. It reads ID, status and address 00h in sequence to show where the pointer went. A stray byte is sent between transactions, and the register it would have hit is read back afterwards to show that nothing changed.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int unsigned ADDR_W     = 7;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned ID_ADDR    = 1;
    localparam int unsigned FIRST_RW   = 2;
    localparam logic [7:0]  ID_VALUE   = 8'hD1;
    localparam logic [6:0]  RESET_PTR  = 7'h01;
    localparam logic        RESET_INCR = 1'b1;

    // Reset value of a read/write byte at address a
    function automatic logic [7:0] rw_default(input int unsigned a);
        return 8'h80 | 8'(a);
    endfunction

    typedef struct packed {
        logic              in_txn;
        logic              need_ptr;
        logic              incr;
        logic [ADDR_W-1:0] ptr;
    } ptr_state_t;
endpackage

// File: rtl/regbank_ptr_ctrl.sv
module regbank_ptr_ctrl
    import regbank_pkg::*;
#(
    parameter int unsigned NUM_RW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              txn_end,
    input  logic              byte_valid,
    input  logic [7:0]        byte_in,
    input  logic              rd_strobe,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              rd_en
);
    localparam int unsigned MAX_ADDR = NUM_RW + FIRST_RW + 1;
    localparam logic [ADDR_W-1:0] MAX_A = ADDR_W'(MAX_ADDR);

    ptr_state_t st_d, st_q;
    logic       adv;

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        rd_en = 1'b0;
        adv   = 1'b0;
        if (txn_start) begin
            st_d.in_txn   = 1'b1;
            st_d.need_ptr = 1'b1;
        end else if (txn_end) begin
            st_d.in_txn   = 1'b0;
            st_d.need_ptr = 1'b0;
        end else if (st_q.in_txn) begin
            if (byte_valid) begin
                if (st_q.need_ptr) begin
                    st_d.incr     = byte_in[7];
                    st_d.ptr      = byte_in[6:0];
                    st_d.need_ptr = 1'b0;
                end else begin
                    wr_en = 1'b1;
                    adv   = 1'b1;
                end
            end else if (rd_strobe) begin
                rd_en         = 1'b1;
                adv           = 1'b1;
                st_d.need_ptr = 1'b0;
            end
        end
        if (adv && st_q.incr) begin
            st_d.ptr = (st_q.ptr >= MAX_A) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{in_txn: 1'b0, need_ptr: 1'b0, incr: RESET_INCR, ptr: RESET_PTR};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_addr = st_q.ptr;
    assign wr_data  = byte_in;

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && st_q.in_txn && st_q.need_ptr && !txn_start && !txn_end)
        |=> (st_q.ptr == $past(byte_in[6:0]) && st_q.incr == $past(byte_in[7])));

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !st_q.incr) |=> $stable(st_q.ptr));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && st_q.incr && st_q.ptr < MAX_A)
        |=> (st_q.ptr == $past(st_q.ptr) + 1'b1));

    assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && st_q.incr && st_q.ptr >= MAX_A) |=> (st_q.ptr == '0));

    assert_idle_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.in_txn && !txn_start) |=> $stable(st_q.ptr));
endmodule

// File: rtl/regbank_rw_file.sv
module regbank_rw_file
    import regbank_pkg::*;
#(
    parameter int unsigned NUM_RW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    output logic [NUM_RW*8-1:0]    cfg_flat
);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(FIRST_RW);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(FIRST_RW + NUM_RW - 1);

    logic [NUM_RW-1:0][7:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_RW; i++) begin
            if (wr_en && wr_addr == ADDR_W'(FIRST_RW + i)) begin
                regs_d[i] = wr_data;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[g] <= rw_default(FIRST_RW + g);
                end else begin
                    regs_q[g] <= regs_d[g];
                end
            end
        end
    endgenerate

    assign cfg_flat = regs_q;

    assert_ro_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr < LO_A || wr_addr > HI_A)) |=> $stable(regs_q));

    assert_rw_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == LO_A) |=> (regs_q[0] == $past(wr_data)));
endmodule

// File: rtl/regbank_rd_mux.sv
module regbank_rd_mux
    import regbank_pkg::*;
#(
    parameter int unsigned NUM_RW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_RW*8-1:0] cfg_flat,
    input  logic [7:0]          stat_in,
    input  logic [7:0]          dout_in,
    output logic [7:0]          rd_data
);
    localparam int unsigned STAT_ADDR = FIRST_RW + NUM_RW;
    localparam int unsigned DOUT_ADDR = STAT_ADDR + 1;
    localparam logic [ADDR_W-1:0] DOUT_A = ADDR_W'(DOUT_ADDR);

    logic [7:0] sel_byte;
    logic [7:0] rd_d, rd_q;

    always_comb begin
        sel_byte = 8'h00;
        if (rd_addr == ADDR_W'(ID_ADDR)) begin
            sel_byte = ID_VALUE;
        end else if (rd_addr == ADDR_W'(STAT_ADDR)) begin
            sel_byte = stat_in;
        end else if (rd_addr == DOUT_A) begin
            sel_byte = dout_in;
        end else begin
            for (int i = 0; i < NUM_RW; i++) begin
                if (rd_addr == ADDR_W'(FIRST_RW + i)) begin
                    sel_byte = cfg_flat[i*8 +: 8];
                end
            end
        end
        rd_d = rd_en ? sel_byte : rd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 8'h00;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

    assert_id_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(ID_ADDR)) |=> (rd_data == 8'hD1));

    assert_unimpl_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == '0 || rd_addr > DOUT_A)) |=> (rd_data == 8'h00));

    assert_stat_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(STAT_ADDR)) |=> (rd_data == $past(stat_in)));
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
    import regbank_pkg::*;
#(
    parameter int unsigned NUM_RW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                txn_start,
    input  logic                txn_end,
    input  logic                byte_valid,
    input  logic [7:0]          byte_in,
    input  logic                rd_strobe,
    input  logic [7:0]          stat_in,
    input  logic [7:0]          dout_in,
    output logic [7:0]          rd_data,
    output logic [NUM_RW*8-1:0] cfg_out
);
    logic [ADDR_W-1:0] acc_addr;
    logic              wr_en;
    logic              rd_en;
    logic [7:0]        wr_data;

    regbank_ptr_ctrl #(.NUM_RW(NUM_RW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_start  (txn_start),
        .txn_end    (txn_end),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .rd_strobe  (rd_strobe),
        .acc_addr   (acc_addr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en)
    );

    regbank_rw_file #(.NUM_RW(NUM_RW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (acc_addr),
        .wr_data  (wr_data),
        .cfg_flat (cfg_out)
    );

    regbank_rd_mux #(.NUM_RW(NUM_RW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (acc_addr),
        .cfg_flat (cfg_out),
        .stat_in  (stat_in),
        .dout_in  (dout_in),
        .rd_data  (rd_data)
    );

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));
endmodule

// File: tb/ctrl_regbank_test.sv
module ctrl_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_RW = 6;
    localparam logic [1:0] OP_S = 2'd0, OP_B = 2'd1, OP_R = 2'd2, OP_E = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 50;
    localparam vec_t VECS [NV] = '{
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_R, 8'h00, 8'hD1, 4'd4},   // R4 / R1: default pointer 01h
        '{OP_R, 8'h00, 8'h82, 4'd1},   // R1: default incr and reg default
        '{OP_E, 8'h00, 8'h00, 4'd0},
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_B, 8'h82, 8'h00, 4'd0},   // R2: pointer 02h, incr on
        '{OP_B, 8'h11, 8'h00, 4'd0},
        '{OP_B, 8'h22, 8'h00, 4'd0},
        '{OP_E, 8'h00, 8'h00, 4'd0},
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_R, 8'h00, 8'h84, 4'd9},   // R9: leftover pointer 04h
        '{OP_E, 8'h00, 8'h00, 4'd0},
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_B, 8'h02, 8'h00, 4'd0},   // incr off
        '{OP_R, 8'h00, 8'h11, 4'd5},   // R5 readback
        '{OP_R, 8'h00, 8'h11, 4'd3},   // R3: pointer held
        '{OP_E, 8'h00, 8'h00, 4'd0},
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_B, 8'h81, 8'h00, 4'd0},
        '{OP_B, 8'hFF, 8'h00, 4'd0},   // write to ID dropped
        '{OP_R, 8'h00, 8'h11, 4'd6},   // R6: pointer moved to 02h
        '{OP_E, 8'h00, 8'h00, 4'd0},
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_B, 8'h88, 8'h00, 4'd0},
        '{OP_R, 8'h00, 8'h5A, 4'd7},   // R7 status
        '{OP_R, 8'h00, 8'h3C, 4'd7},   // R7 data out
        '{OP_R, 8'h00, 8'h00, 4'd8},   // R8 wrapped to 00h
        '{OP_R, 8'h00, 8'hD1, 4'd8},   // R8 then 01h
        '{OP_E, 8'h00, 8'h00, 4'd0},
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_B, 8'h89, 8'h00, 4'd0},
        '{OP_B, 8'h77, 8'h00, 4'd0},   // RO write dropped, wrap
        '{OP_B, 8'h55, 8'h00, 4'd0},   // addr 00h write dropped
        '{OP_R, 8'h00, 8'hD1, 4'd6},   // R6 pointer reached 01h
        '{OP_E, 8'h00, 8'h00, 4'd0},
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_B, 8'h85, 8'h00, 4'd0},
        '{OP_B, 8'h66, 8'h00, 4'd0},
        '{OP_E, 8'h00, 8'h00, 4'd0},
        '{OP_B, 8'h99, 8'h00, 4'd0},   // outside a transaction
        '{OP_R, 8'h00, 8'hD1, 4'd11},  // R11 read ignored, R10 hold
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_B, 8'h85, 8'h00, 4'd0},
        '{OP_R, 8'h00, 8'h66, 4'd5},   // R5
        '{OP_R, 8'h00, 8'h86, 4'd11},  // R11 stray byte not written
        '{OP_E, 8'h00, 8'h00, 4'd0},
        '{OP_S, 8'h00, 8'h00, 4'd0},
        '{OP_B, 8'h70, 8'h00, 4'd0},
        '{OP_R, 8'h00, 8'h00, 4'd8},   // R8 unimplemented reads 00h
        '{OP_E, 8'h00, 8'h00, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_start = 1'b0, txn_end = 1'b0, byte_valid = 1'b0, rd_strobe = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [7:0] stat_in = 8'h5A;
    logic [7:0] dout_in = 8'h3C;
    logic [7:0] rd_data;
    logic [NUM_RW*8-1:0] cfg_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    int cycles = 0;

    ctrl_regbank #(.NUM_RW(NUM_RW)) uut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_end(txn_end),
        .byte_valid(byte_valid), .byte_in(byte_in), .rd_strobe(rd_strobe),
        .stat_in(stat_in), .dout_in(dout_in), .rd_data(rd_data), .cfg_out(cfg_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive after a falling edge, hold for one rising edge, sample at the next falling edge
    task automatic do_op(input logic [1:0] op, input logic [7:0] d);
        txn_start  = (op == OP_S);
        byte_valid = (op == OP_B);
        rd_strobe  = (op == OP_R);
        txn_end    = (op == OP_E);
        byte_in    = d;
        @(negedge clk);
        txn_start = 1'b0; byte_valid = 1'b0; rd_strobe = 1'b0; txn_end = 1'b0;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                n_fail++;
                $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rd_data", 64'(rd_data), 64'h00);
        check("R1 cfg_out", 64'(cfg_out), 64'h878685848382);

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].data);
            if (VECS[i].op == OP_R) begin
                check($sformatf("R%0d vector %0d", VECS[i].req, i), 64'(rd_data), 64'(VECS[i].exp));
            end
        end

        // R5: write results on the config bus
        check("R5 cfg_out", 64'(cfg_out), 64'h878666842211);

        // R10: value held over idle cycles
        repeat (4) @(negedge clk);
        check("R10 hold", 64'(rd_data), 64'h00);

        // R11: start outranks a byte in the same cycle
        txn_start = 1'b1; byte_valid = 1'b1; byte_in = 8'h83;
        @(negedge clk);
        txn_start = 1'b0; byte_valid = 1'b0;
        do_op(OP_B, 8'h07);          // this is the pointer byte: 07h, incr off
        do_op(OP_R, 8'h00);
        check("R11 start priority", 64'(rd_data), 64'h87);
        do_op(OP_R, 8'h00);
        check("R3 hold incr off", 64'(rd_data), 64'h87);
        do_op(OP_E, 8'h00);

        // R1: reset mid-use restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset rd_data", 64'(rd_data), 64'h00);
        check("R1 reset cfg_out", 64'(cfg_out), 64'h878685848382);
        do_op(OP_S, 8'h00);
        do_op(OP_R, 8'h00);
        check("R1 reset pointer", 64'(rd_data), 64'hD1);
        do_op(OP_R, 8'h00);
        check("R1 reset incr", 64'(rd_data), 64'h82);
        do_op(OP_E, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule